// File: doc/BRIEF.md
# Serial-bus tuner synthesizer control port

This block is a two-wire serial slave that sits between a control processor and the frequency synthesizer of a tuner. It accepts a 15-bit loop divide word and a set of control fields: reference divider code, charge-pump current code, band, IF passband select, four general-purpose switch outputs and a test-mode code. It returns a one-byte status carrying a power-fail flag and a lock flag. The two low bits of its bus address come from strap inputs, so several copies can share one bus.

Each data byte identifies itself by its most significant bit. A byte starting with 0 opens a frequency pair, and a byte starting with 1 opens a control pair. The byte that follows is always taken as the second half of that pair. The new divide word is held back until both of its bytes have arrived, so the loop never sees a half-updated value. A STOP that follows a lone high byte commits that byte together with the previously held low byte.

Reads return the status byte for as long as the master acknowledges. A missing acknowledge ends the read inside the slave, which then leaves the data line alone.

Top module: `tuner_i2c_ctrl`

## Requirements
- R1: The slave acknowledges an address byte only if its upper seven bits equal binary 11000 followed by strap_i[1], strap_i[0]. Bit 0 of the address byte is 0 for a write and 1 for a read. It leaves SDA released for any other address.
- R2: In a write transfer, the slave pulls SDA low in the acknowledge slot after every data byte, and only while SCL is low at the moment it starts driving.
- R3: A data byte with bit 7 = 0 supplies divide bits 14..8 from its bits 6..0, and the next byte supplies divide bits 7..0. div_o keeps its old value until that second byte is complete and changes only on a completed byte or on STOP.
- R4: A data byte with bit 7 = 1 sets cp_code_o from bits 6..5 and ref_code_o from bits 4..0. The next byte sets if_sel_o from bit 7, band_o from bits 6..5 and test_en_o from bit 4. Bits 3..0 of that byte are the port states, and bits 3..1 are also the test code.
- R5: Several byte pairs of either kind may follow one address without a new START, and each is decoded by the same rule.
- R6: A STOP after a lone frequency high byte sets div_o to that byte's seven bits above the previously held low byte. A STOP in the middle of a byte discards that partial byte and leaves all outputs unchanged.
- R7: A repeated START discards a pending frequency high byte, so div_o does not change.
- R8: In a read transfer, the status byte is {POR, FL, 6'b0}, sent MSB first. It is sent again after each byte the master acknowledges. FL follows lock_i outside the forced test modes.
- R9: POR is 1 after reset and after any cycle with pwr_fail_i high. It returns to 0 on a STOP that ends a transfer which addressed the slave for reading.
- R10: When the master does not acknowledge a status byte, the slave releases SDA and drives no further bits until the next START. It also releases SDA on every STOP.
- R11: With test_en_o = 1, port_o is 0 and the stored port bits are cleared. cp_mode_o equals the low two test bits: 00 normal, 01 sink, 10 source, 11 off. FL reads 0 for codes x01 and x10, and 1 for codes x11.
- R12: mon_sel_o is 00 when test_en_o is 0 or the test code is 0xx. It is 01 (halved divider output) for code 100, and 10 (comparison frequency) for codes 101, 110 and 111. At most one bit of mon_sel_o is ever set.
- R13: port_o is 0 after reset. When a control byte B with bit 4 = 0 is received, port_o takes that byte's bits 3..0, active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 2 | Low two address bits |
| lock_i | input | 1 | Loop lock indication |
| pwr_fail_i | input | 1 | Supply-fail event, sets POR |
| div_o | output | 15 | Loop divide word |
| ref_code_o | output | 5 | Reference divider code |
| cp_code_o | output | 2 | Charge-pump current code |
| band_o | output | 2 | Oscillator band select |
| if_sel_o | output | 1 | IF passband select |
| port_o | output | 4 | Switch outputs, 1 = on |
| test_en_o | output | 1 | Test mode enabled |
| test_code_o | output | 3 | Test code |
| cp_mode_o | output | 2 | Charge-pump force: 00 normal, 01 sink, 10 source, 11 off |
| mon_sel_o | output | 2 | Monitor routing to port 0: 00 none, 01 divider/2, 10 comparison |

## Verification
The address decode is swept over all sixteen combinations of strap value and address bits, which separates a correct compare from one that ignores either strap bit.

Divide words are written with several spread-out values. Each value is checked after the high byte and again after the low byte, which separates atomic commit from byte-by-byte update.

Single pairs, mixed pairs in one transfer, a STOP after a lone high byte, a STOP in mid-byte and a repeated START each exercise one commit path. All eight test codes are tried with lock asserted, so the forced lock values can be told apart from the real one. Reads with acknowledge, without acknowledge, and after a power-fail pulse show when POR is set and cleared, and when the bus is released.

// File: rtl/tuner_ctrl_pkg.sv
package tuner_ctrl_pkg;
  localparam int DIV_W  = 15;
  localparam int REF_W  = 5;
  localparam int CP_W   = 2;
  localparam int BAND_W = 2;
  localparam int PORT_W = 4;
  localparam int TEST_W = 3;
  localparam int HI_W   = DIV_W - 8;
  localparam logic [4:0] ADDR_PREFIX = 5'b11000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WR, ST_ACK, ST_RD, ST_RACK
  } i2c_state_e;
endpackage

// File: rtl/tuner_i2c_sampler.sv
module tuner_i2c_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s_o    = scl_p[STAGES-1];
  assign sda_s_o    = sda_p[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  // data edges while clock stays high
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/tuner_i2c_engine.sv
module tuner_i2c_engine
  import tuner_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_s_i,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [1:0] strap_i,
  input  logic [7:0] status_i,
  output logic       sda_oe_o,
  output logic       byte_done_o,
  output logic [7:0] byte_o,
  output logic       rd_stop_o
);
  i2c_state_e state_q;
  logic [7:0] sh_q, tx_q;
  logic [3:0] cnt_q;
  logic       oe_q, rw_q, macked_q, rd_sess_q;
  logic       last_bit;

  assign last_bit = (cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      tx_q      <= '0;
      cnt_q     <= '0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      macked_q  <= 1'b0;
      rd_sess_q <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      cnt_q     <= '0;
      oe_q      <= 1'b0;
      rd_sess_q <= 1'b0;
    end else if (stop_i) begin
      state_q   <= ST_IDLE;
      oe_q      <= 1'b0;
      rd_sess_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[6:0], sda_s_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall_i && last_bit) begin
            if (state_q == ST_WR) begin
              oe_q    <= 1'b1;
              state_q <= ST_ACK;
            end else if (sh_q[7:1] == {ADDR_PREFIX, strap_i}) begin
              oe_q      <= 1'b1;
              rw_q      <= sh_q[0];
              rd_sess_q <= sh_q[0];
              state_q   <= ST_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ACK: if (scl_fall_i) begin
          cnt_q <= '0;
          if (rw_q) begin
            tx_q    <= status_i;
            oe_q    <= ~status_i[7];
            state_q <= ST_RD;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (last_bit) begin
              oe_q    <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            macked_q <= ~sda_s_i;
          end else if (scl_fall_i) begin
            if (macked_q) begin
              cnt_q   <= '0;
              tx_q    <= status_i;
              oe_q    <= ~status_i[7];
              state_q <= ST_RD;
            end else begin
              state_q <= ST_IDLE;  // internal stop
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o    = oe_q;
  assign byte_o      = sh_q;
  assign byte_done_o = (state_q == ST_WR) && scl_fall_i && last_bit && !start_i && !stop_i;
  assign rd_stop_o   = stop_i && rd_sess_q;

  assert_oe_low_clock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_s_i);
  assert_release_on_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !oe_q);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);
endmodule

// File: rtl/tuner_ctrl_regs.sv
module tuner_ctrl_regs
  import tuner_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_done_i,
  input  logic [7:0]        byte_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rd_stop_i,
  input  logic              lock_i,
  input  logic              pwr_fail_i,
  output logic [7:0]        status_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [REF_W-1:0]  ref_code_o,
  output logic [CP_W-1:0]   cp_code_o,
  output logic [BAND_W-1:0] band_o,
  output logic              if_sel_o,
  output logic [PORT_W-1:0] port_o,
  output logic              test_en_o,
  output logic [TEST_W-1:0] test_code_o,
  output logic [1:0]        cp_mode_o,
  output logic [1:0]        mon_sel_o
);
  logic [DIV_W-1:0]  div_q;
  logic [HI_W-1:0]   pend_hi_q;
  logic              pend_vld_q, second_q, ctrl_pair_q, por_q;
  logic [REF_W-1:0]  ref_q;
  logic [CP_W-1:0]   cp_q;
  logic [BAND_W-1:0] band_q;
  logic              if_q, te_q;
  logic [PORT_W-1:0] port_q;
  logic [TEST_W-1:0] test_q;
  logic              fl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q       <= '0;
      pend_hi_q   <= '0;
      pend_vld_q  <= 1'b0;
      second_q    <= 1'b0;
      ctrl_pair_q <= 1'b0;
      ref_q       <= '0;
      cp_q        <= '0;
      band_q      <= '0;
      if_q        <= 1'b0;
      te_q        <= 1'b0;
      port_q      <= '0;
      test_q      <= '0;
    end else if (start_i) begin
      pend_vld_q <= 1'b0;  // repeated start drops pending word
      second_q   <= 1'b0;
    end else if (stop_i) begin
      if (pend_vld_q) div_q <= {pend_hi_q, div_q[7:0]};
      pend_vld_q <= 1'b0;
      second_q   <= 1'b0;
    end else if (byte_done_i) begin
      second_q <= ~second_q;
      if (!second_q) begin
        ctrl_pair_q <= byte_i[7];
        if (byte_i[7]) begin
          cp_q  <= byte_i[6:5];
          ref_q <= byte_i[4:0];
        end else begin
          pend_hi_q  <= byte_i[HI_W-1:0];
          pend_vld_q <= 1'b1;
        end
      end else if (!ctrl_pair_q) begin
        div_q      <= {pend_hi_q, byte_i};
        pend_vld_q <= 1'b0;
      end else begin
        if_q   <= byte_i[7];
        band_q <= byte_i[6:5];
        te_q   <= byte_i[4];
        if (byte_i[4]) begin
          test_q <= byte_i[3:1];
          port_q <= '0;
        end else begin
          test_q <= '0;
          port_q <= byte_i[3:0];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         por_q <= 1'b1;
    else if (pwr_fail_i) por_q <= 1'b1;
    else if (rd_stop_i)  por_q <= 1'b0;
  end

  always_comb begin
    fl        = lock_i;
    cp_mode_o = 2'b00;
    mon_sel_o = 2'b00;
    if (te_q) begin
      cp_mode_o = test_q[1:0];
      if (test_q[1:0] != 2'b00) fl = (test_q[1:0] == 2'b11);
      if (test_q[2]) mon_sel_o = (test_q[1:0] == 2'b00) ? 2'b01 : 2'b10;
    end
  end

  assign status_o    = {por_q, fl, 6'b0};
  assign div_o       = div_q;
  assign ref_code_o  = ref_q;
  assign cp_code_o   = cp_q;
  assign band_o      = band_q;
  assign if_sel_o    = if_q;
  assign port_o      = port_q;
  assign test_en_o   = te_q;
  assign test_code_o = test_q;

  assert_div_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_done_i || stop_i) |=> $stable(div_q));
  assert_por_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> por_q);
  assert_test_ports_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    te_q |-> (port_q == '0));
  assert_mon_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mon_sel_o));
endmodule

// File: rtl/tuner_i2c_ctrl.sv
module tuner_i2c_ctrl
  import tuner_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        strap_i,
  input  logic              lock_i,
  input  logic              pwr_fail_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [REF_W-1:0]  ref_code_o,
  output logic [CP_W-1:0]   cp_code_o,
  output logic [BAND_W-1:0] band_o,
  output logic              if_sel_o,
  output logic [PORT_W-1:0] port_o,
  output logic              test_en_o,
  output logic [TEST_W-1:0] test_code_o,
  output logic [1:0]        cp_mode_o,
  output logic [1:0]        mon_sel_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic byte_done, rd_stop;
  logic [7:0] byte_val, status;

  tuner_i2c_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  tuner_i2c_engine u_engine (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .strap_i, .status_i(status),
    .sda_oe_o, .byte_done_o(byte_done), .byte_o(byte_val), .rd_stop_o(rd_stop)
  );

  tuner_ctrl_regs u_regs (
    .clk_i, .rst_ni, .byte_done_i(byte_done), .byte_i(byte_val),
    .start_i(start), .stop_i(stop), .rd_stop_i(rd_stop),
    .lock_i, .pwr_fail_i, .status_o(status),
    .div_o, .ref_code_o, .cp_code_o, .band_o, .if_sel_o, .port_o,
    .test_en_o, .test_code_o, .cp_mode_o, .mon_sel_o
  );
endmodule

// File: tb/tuner_i2c_ctrl_tb.sv
module tuner_i2c_ctrl_tb;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic lock = 1'b0, pfail = 1'b0;
  logic [1:0] strap = 2'b00;
  logic sda_bus, sda_oe;
  logic [14:0] div;
  logic [4:0] ref_code;
  logic [1:0] cp_code, band, cp_mode, mon_sel;
  logic if_sel, test_en;
  logic [3:0] port;
  logic [2:0] test_code;

  assign sda_bus = sda_m & ~sda_oe;
  always #4 clk = ~clk;

  tuner_i2c_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .lock_i(lock), .pwr_fail_i(pfail),
    .div_o(div), .ref_code_o(ref_code), .cp_code_o(cp_code), .band_o(band),
    .if_sel_o(if_sel), .port_o(port), .test_en_o(test_en), .test_code_o(test_code),
    .cp_mode_o(cp_mode), .mon_sel_o(mon_sel)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [14:0] exp_div = '0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
    bit_out(~give_ack);
  endtask

  task automatic read_status(output logic [7:0] v);
    logic a;
    i2c_start(); send_byte(8'hC5, a); read_byte(1'b0, v); i2c_stop();
  endtask

  task automatic write_ctrl(input logic [1:0] cp, input logic [4:0] rc, input logic ifs,
                            input logic [1:0] bd, input logic te, input logic [3:0] low4);
    logic a;
    i2c_start(); send_byte(8'hC4, a);
    send_byte({1'b1, cp, rc}, a); send_byte({ifs, bd, te, low4}, a);
    i2c_stop();
  endtask

  initial begin
    repeat ((200000 - 10000)) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all R actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R13 reset ports", port, 0);
    chk("R3 reset div", div, 0);
    chk("R11 reset cp_mode", cp_mode, 0);
    chk("R12 reset mon_sel", mon_sel, 0);

    // R1 address sweep
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int m = 0; m < 4; m++) begin
        i2c_start(); send_byte({5'b11000, 2'(m), 1'b0}, a); i2c_stop();
        chk("R1 address ack", a, (m == s) ? 1 : 0);
      end
    end
    strap = 2'b10;

    // R8 R9 R10 reads
    lock = 1'b1;
    i2c_start(); send_byte(8'hC5, a);
    chk("R1 read address ack", a, 1);
    read_byte(1'b1, v); chk("R8 status first", v, 8'hC0);
    read_byte(1'b0, v); chk("R8 status repeated", v, 8'hC0);
    for (int i = 7; i >= 0; i--) begin bit_in(a); v[i] = a; end
    chk("R10 bus released after nack", v, 8'hFF);
    i2c_stop();
    read_status(v); chk("R9 por cleared by read stop", v, 8'h40);
    lock = 1'b0;
    read_status(v); chk("R8 unlocked status", v, 8'h00);
    @(negedge clk); pfail = 1'b1; @(negedge clk); pfail = 1'b0;
    read_status(v); chk("R9 por set by power fail", v, 8'h80);
    read_status(v); chk("R9 por cleared again", v, 8'h00);

    // R2 R3 frequency pairs
    for (int i = 0; i < 8; i++) begin
      logic [14:0] w;
      w = 15'((i * 4679 + 123) & 32'h7FFF);
      i2c_start(); send_byte(8'hC4, a);
      send_byte({1'b0, w[14:8]}, a); chk("R2 ack high byte", a, 1);
      chk("R3 div held after high byte", div, exp_div);
      send_byte(w[7:0], a); chk("R2 ack low byte", a, 1);
      chk("R3 div after low byte", div, w);
      exp_div = w;
      i2c_stop();
    end

    // R4 R5 mixed pairs in one transfer
    for (int c = 0; c < 4; c++) begin
      logic [14:0] w;
      logic [4:0] rc;
      logic [3:0] pv;
      w  = 15'((c * 9001 + 77) & 32'h7FFF);
      rc = 5'(c * 7 + 3);
      pv = 4'(c * 5 + 1);
      i2c_start(); send_byte(8'hC4, a);
      send_byte({1'b1, 2'(c), rc}, a);
      send_byte({c[0], 2'(c), 1'b0, pv}, a);
      send_byte({1'b0, w[14:8]}, a);
      send_byte(w[7:0], a);
      i2c_stop();
      exp_div = w;
      chk("R4 cp code", cp_code, c);
      chk("R4 ref code", ref_code, rc);
      chk("R4 if select", if_sel, c & 1);
      chk("R4 band", band, c);
      chk("R13 ports follow byte", port, pv);
      chk("R5 div in same transfer", div, w);
    end

    // R6 stop after lone high byte
    i2c_start(); send_byte(8'hC4, a); send_byte({1'b0, 7'h55}, a); i2c_stop();
    exp_div = {7'h55, exp_div[7:0]};
    chk("R6 stop commits high byte", div, exp_div);
    // R6 stop mid byte
    i2c_start(); send_byte(8'hC4, a); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); i2c_stop();
    chk("R6 partial byte discarded", div, exp_div);
    chk("R6 partial byte ports kept", port, 4'(3 * 5 + 1));
    // R7 repeated start
    i2c_start(); send_byte(8'hC4, a); send_byte({1'b0, 7'h2A}, a);
    i2c_start(); send_byte(8'hC4, a); i2c_stop();
    chk("R7 repeated start drops pending", div, exp_div);

    // R11 R12 test code sweep
    lock = 1'b1;
    for (int t = 0; t < 8; t++) begin
      logic [2:0] tc;
      int efl, emon;
      tc = 3'(t);
      write_ctrl(2'b01, 5'd2, 1'b0, 2'b01, 1'b1, {tc, 1'b1});
      chk("R11 ports off in test", port, 0);
      chk("R11 cp_mode", cp_mode, tc[1:0]);
      emon = !tc[2] ? 0 : (tc == 3'b100) ? 1 : 2;
      chk("R12 mon_sel", mon_sel, emon);
      efl = (tc[1:0] == 2'b00) ? 1 : (tc[1:0] == 2'b11) ? 1 : 0;
      read_status(v);
      chk("R11 forced lock flag", v, efl ? 8'h40 : 8'h00);
    end
    write_ctrl(2'b00, 5'd1, 1'b0, 2'b00, 1'b0, 4'b1011);
    chk("R13 ports after test exit", port, 4'b1011);
    chk("R11 cp_mode normal", cp_mode, 0);
    chk("R12 mon_sel none", mon_sel, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule